// File: doc/BRIEF.md
# Panel Power Sequencing Controller

This block takes a display controller through its power-up and power-down sequences. It works by handing register writes, one at a time, to an attached serial command writer. The writer performs the 9-bit serialization. This block decides what is written, in what order, and when.

A one-cycle `en_req` strobe starts the power-up sequence and a `dis_req` strobe starts the power-down sequence. Power-up opens with a wake preamble of three empty commands to address 0x00, with a timed gap after each one. A failed preamble write aborts the sequence before any configuration write is sent. After a clean preamble, the configuration steps come from an internal step ROM. Errors on those steps are collected and do not stop the sequence. When a sequence ends, `busy` drops and `status` holds the outcome until the next sequence starts.

Top module: `panel_pwr_seq`

## Requirements
- R1: While reset is held, and on the first cycle after it, `busy` is 0, `wr_req` is 0 and `status` is 2'b00.
- R2: Once `wr_req` rises, it and `wr_addr`, `wr_len` and `wr_data` hold steady until `wr_done` is sampled. `wr_req` is low in the cycle after `wr_done`, so only one write is outstanding at a time.
- R3: An `en_req` in idle starts power-up with three writes of length code 0 (no payload) to address 0x00.
- R4: After each preamble write completes without error, `wr_req` stays low for exactly GAP_CYC = (CLK_HZ/1000)*GAP_US/1000 cycles before the next request (1.5 ms by default).
- R5: If any preamble write returns `wr_err`, no further write is requested, `busy` drops and `status` becomes 2'b11.
- R6: After the preamble, power-up issues 41 writes in a fixed order. They begin with B0←17, BC←80, 3B←00, B0←16, then B8←FFF9 (length 2), then 11 with no payload. They include BD←04 and end with 29 with no payload. Length code 1 sends `wr_data[7:0]`. Length code 2 sends `wr_data[15:0]`, high byte first.
- R7: After the preamble, each `wr_err` is ORed into an error flag and the sequence runs to its end. The final status is 2'b10 if any error was seen and 2'b01 if none was.
- R8: A `dis_req` in idle issues four writes: 28 (length 0), B8←8002 (length 2), 10 (length 0) and B0←00 (length 1). The final status follows R7.
- R9: `en_req` and `dis_req` are ignored while `busy` is high. `busy` stays high until the final status is posted, and no write is requested while `busy` is low.
- R10: If both strobes arrive in the same idle cycle, the power-down sequence runs.
- R11: `status` is cleared to 2'b00 when a sequence starts and is otherwise held from the end of one sequence until the next one starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_req | input | 1 | Power-up start strobe |
| dis_req | input | 1 | Power-down start strobe |
| busy | output | 1 | High while a sequence runs |
| status | output | 2 | 00 none, 01 ok, 10 write error, 11 preamble abort |
| wr_req | output | 1 | Write request to the command writer |
| wr_addr | output | 8 | Command or register address |
| wr_len | output | 2 | Payload byte count: 0, 1 or 2 |
| wr_data | output | 16 | Payload; a 1-byte payload sits in bits 7:0 |
| wr_done | input | 1 | One-cycle completion pulse from the writer |
| wr_err | input | 1 | Error flag, valid with `wr_done` |

## Verification
A wrong step index shows up at the write ports on the very next request, as an address, length or payload that is out of order. A lost or duplicated step changes the request count before `busy` falls. A broken delay counter moves the request that follows a preamble write by at least one cycle. Errors that are dropped or stuck show in `status` in the cycle after the end-of-list marker is reached. A preamble failure that is not taken up shows as a configuration request where none may appear.

// File: rtl/pps_pkg.sv
// Shared types and constants for the panel power sequencer.
// Assumes the step ROM holds power-up steps first, then power-down steps.
package pps_pkg;

    // Payload length codes; LEN_END marks the end of a step list.
    localparam logic [1:0] LEN_NONE = 2'd0;
    localparam logic [1:0] LEN_ONE  = 2'd1;
    localparam logic [1:0] LEN_TWO  = 2'd2;
    localparam logic [1:0] LEN_END  = 2'd3;

    // Final status codes.
    localparam logic [1:0] ST_NONE  = 2'b00;
    localparam logic [1:0] ST_OK    = 2'b01;
    localparam logic [1:0] ST_ERR   = 2'b10;
    localparam logic [1:0] ST_ABORT = 2'b11;

    // Step ROM layout.
    localparam int PU_STEPS  = 41;
    localparam int PD_STEPS  = 4;
    localparam int PU_BASE   = 0;
    localparam int PD_BASE   = PU_BASE + PU_STEPS + 1;
    localparam int ROM_DEPTH = PD_BASE + PD_STEPS + 1;
    localparam int IDX_W     = $clog2(ROM_DEPTH);

    // Address used by the wake preamble.
    localparam logic [7:0] PRE_ADDR = 8'h00;

    typedef struct packed {
        logic [1:0]  len;
        logic [7:0]  addr;
        logic [15:0] data;
    } step_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PRE_REQ,
        S_PRE_DLY,
        S_RUN,
        S_GAP
    } seq_state_t;

endpackage

// File: rtl/pps_step_rom.sv
// Step ROM: maps a step index to a {length, address, payload} entry.
// Power-up list at PU_BASE, power-down list at PD_BASE, each closed by an
// end marker. Any index past the table also reads as an end marker.
module pps_step_rom
    import pps_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    output step_t            step
);

    // Builds one entry from its parts.
    function automatic step_t mk(input logic [1:0] l, input logic [7:0] a,
                                 input logic [15:0] d);
        step_t s;
        s.len  = l;
        s.addr = a;
        s.data = d;
        return s;
    endfunction

    // Combinational table lookup.
    always_comb begin
        case (idx)
            6'd0:  step = mk(LEN_ONE,  8'hB0, 16'h0017);
            6'd1:  step = mk(LEN_ONE,  8'hBC, 16'h0080);
            6'd2:  step = mk(LEN_ONE,  8'h3B, 16'h0000);
            6'd3:  step = mk(LEN_ONE,  8'hB0, 16'h0016);
            6'd4:  step = mk(LEN_TWO,  8'hB8, 16'hFFF9);
            6'd5:  step = mk(LEN_NONE, 8'h11, 16'h0000);
            6'd6:  step = mk(LEN_ONE,  8'hBA, 16'h0001);
            6'd7:  step = mk(LEN_ONE,  8'hBB, 16'h0000);
            6'd8:  step = mk(LEN_ONE,  8'h3A, 16'h0060);
            6'd9:  step = mk(LEN_ONE,  8'hBF, 16'h0010);
            6'd10: step = mk(LEN_ONE,  8'hB1, 16'h0056);
            6'd11: step = mk(LEN_ONE,  8'hB2, 16'h0033);
            6'd12: step = mk(LEN_ONE,  8'hB3, 16'h0011);
            6'd13: step = mk(LEN_ONE,  8'hB3, 16'h0011);
            6'd14: step = mk(LEN_ONE,  8'hB4, 16'h0002);
            6'd15: step = mk(LEN_ONE,  8'hB5, 16'h002B);
            6'd16: step = mk(LEN_ONE,  8'hB6, 16'h0040);
            6'd17: step = mk(LEN_ONE,  8'hB7, 16'h0003);
            6'd18: step = mk(LEN_ONE,  8'hB9, 16'h0004);
            6'd19: step = mk(LEN_ONE,  8'hBD, 16'h0004);
            6'd20: step = mk(LEN_ONE,  8'hBE, 16'h0000);
            6'd21: step = mk(LEN_ONE,  8'hC0, 16'h0011);
            6'd22: step = mk(LEN_ONE,  8'hC1, 16'h0011);
            6'd23: step = mk(LEN_ONE,  8'hC2, 16'h0011);
            6'd24: step = mk(LEN_TWO,  8'hC3, 16'h2040);
            6'd25: step = mk(LEN_TWO,  8'hC4, 16'h60C0);
            6'd26: step = mk(LEN_TWO,  8'hC5, 16'h1020);
            6'd27: step = mk(LEN_TWO,  8'hC6, 16'h60C0);
            6'd28: step = mk(LEN_TWO,  8'hC7, 16'h5533);
            6'd29: step = mk(LEN_ONE,  8'hC8, 16'h0000);
            6'd30: step = mk(LEN_ONE,  8'hC9, 16'h0000);
            6'd31: step = mk(LEN_ONE,  8'hCA, 16'h0000);
            6'd32: step = mk(LEN_TWO,  8'hEC, 16'h01F0);
            6'd33: step = mk(LEN_ONE,  8'hCF, 16'h0002);
            6'd34: step = mk(LEN_TWO,  8'hD0, 16'h0804);
            6'd35: step = mk(LEN_ONE,  8'hD1, 16'h0001);
            6'd36: step = mk(LEN_TWO,  8'hD2, 16'h0000);
            6'd37: step = mk(LEN_TWO,  8'hD3, 16'h0D0E);
            6'd38: step = mk(LEN_TWO,  8'hD4, 16'h11A4);
            6'd39: step = mk(LEN_ONE,  8'hD5, 16'h000E);
            6'd40: step = mk(LEN_NONE, 8'h29, 16'h0000);
            6'd41: step = mk(LEN_END,  8'h00, 16'h0000);
            6'd42: step = mk(LEN_NONE, 8'h28, 16'h0000);
            6'd43: step = mk(LEN_TWO,  8'hB8, 16'h8002);
            6'd44: step = mk(LEN_NONE, 8'h10, 16'h0000);
            6'd45: step = mk(LEN_ONE,  8'hB0, 16'h0000);
            default: step = mk(LEN_END, 8'h00, 16'h0000);
        endcase
    end

endmodule

// File: rtl/pps_delay_timer.sv
// One-shot delay timer. A start pulse arms it, and expired goes high for one
// cycle GAP_CYC cycles after the start edge. A new start while it is
// running re-arms it. Assumes GAP_CYC >= 1.
module pps_delay_timer #(
    parameter int GAP_CYC = 1500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic expired
);

    localparam int CW = $clog2(GAP_CYC + 1);

    logic [CW-1:0] cnt;
    logic          run;

    assign expired = run && (cnt == '0);

    // Counts down from GAP_CYC-1 to zero, then disarms.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            run <= 1'b0;
        end else if (start) begin
            cnt <= CW'(GAP_CYC - 1);
            run <= 1'b1;
        end else if (run) begin
            if (cnt == '0) run <= 1'b0;
            else           cnt <= cnt - CW'(1);
        end
    end

    // R4: the expiry is a single-cycle event
    assert_expiry_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        expired && !start |=> !expired);

endmodule

// File: rtl/pps_seq_ctrl.sv
// Sequence controller. It runs the wake preamble, then walks the step ROM
// and drives the writer handshake. It assumes wr_done is a one-cycle pulse,
// with wr_err valid in the same cycle. Start strobes are only looked at in
// idle.
module pps_seq_ctrl
    import pps_pkg::*;
#(
    parameter int PRE_COUNT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_req,
    input  logic             dis_req,
    input  step_t            step,
    output logic [IDX_W-1:0] step_idx,
    output logic             tmr_start,
    input  logic             tmr_expired,
    output logic             busy,
    output logic [1:0]       status,
    output logic             wr_req,
    output logic [7:0]       wr_addr,
    output logic [1:0]       wr_len,
    output logic [15:0]      wr_data,
    input  logic             wr_done,
    input  logic             wr_err
);

    localparam int PW = $clog2(PRE_COUNT + 1);

    seq_state_t       state;
    logic [IDX_W-1:0] idx;
    logic [PW-1:0]    pre_cnt;
    logic             err_acc;
    logic             at_end;

    assign step_idx  = idx;
    assign at_end    = (step.len == LEN_END);
    assign tmr_start = (state == S_PRE_REQ) && wr_done && !wr_err;

    // Drives the request toward the writer from the current state and step.
    always_comb begin
        wr_req  = (state == S_PRE_REQ) || ((state == S_RUN) && !at_end);
        wr_addr = (state == S_PRE_REQ) ? PRE_ADDR : step.addr;
        wr_len  = (state == S_PRE_REQ) ? LEN_NONE : step.len;
        wr_data = (state == S_PRE_REQ) ? 16'h0000 : step.data;
    end

    // Main sequencing state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            idx     <= '0;
            pre_cnt <= '0;
            err_acc <= 1'b0;
            busy    <= 1'b0;
            status  <= ST_NONE;
        end else begin
            case (state)
                S_IDLE: begin
                    if (dis_req) begin
                        idx     <= IDX_W'(PD_BASE);
                        err_acc <= 1'b0;
                        busy    <= 1'b1;
                        status  <= ST_NONE;
                        state   <= S_RUN;
                    end else if (en_req) begin
                        idx     <= IDX_W'(PU_BASE);
                        pre_cnt <= '0;
                        err_acc <= 1'b0;
                        busy    <= 1'b1;
                        status  <= ST_NONE;
                        state   <= S_PRE_REQ;
                    end
                end
                S_PRE_REQ: begin
                    if (wr_done) begin
                        if (wr_err) begin
                            status <= ST_ABORT;
                            busy   <= 1'b0;
                            state  <= S_IDLE;
                        end else begin
                            state  <= S_PRE_DLY;
                        end
                    end
                end
                S_PRE_DLY: begin
                    if (tmr_expired) begin
                        if (pre_cnt == PW'(PRE_COUNT - 1)) begin
                            state <= S_RUN;
                        end else begin
                            pre_cnt <= pre_cnt + PW'(1);
                            state   <= S_PRE_REQ;
                        end
                    end
                end
                S_RUN: begin
                    if (at_end) begin
                        status <= err_acc ? ST_ERR : ST_OK;
                        busy   <= 1'b0;
                        state  <= S_IDLE;
                    end else if (wr_done) begin
                        err_acc <= err_acc | wr_err;
                        idx     <= idx + IDX_W'(1);
                        state   <= S_GAP;
                    end
                end
                S_GAP: state <= S_RUN;
                default: state <= S_IDLE;
            endcase
        end
    end

    // R2: request drops right after completion
    assert_req_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |=> !wr_req);

    // R2: request and its fields hold until completion
    assert_req_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req && !wr_done |=> wr_req && $stable(wr_addr) && $stable(wr_len)
                               && $stable(wr_data));

    // R9: no write is requested while not busy
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !wr_req);

    // R11: a final status is posted whenever busy falls
    assert_final_status_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> status != ST_NONE);

    // R11: status is held while idle with no strobe
    assert_status_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !en_req && !dis_req |=> $stable(status));

    // R4: preamble waits leave only on timer expiry
    assert_delay_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PRE_DLY) && !tmr_expired |=> (state == S_PRE_DLY));

endmodule

// File: rtl/panel_pwr_seq.sv
// Top of the panel power sequencer. It ties together the step ROM, the
// preamble delay timer and the sequence controller. CLK_HZ is the system
// clock frequency; GAP_US is the preamble gap in microseconds.
module panel_pwr_seq #(
    parameter int CLK_HZ    = 125_000_000,
    parameter int GAP_US    = 1500,
    parameter int PRE_COUNT = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en_req,
    input  logic        dis_req,
    output logic        busy,
    output logic [1:0]  status,
    output logic        wr_req,
    output logic [7:0]  wr_addr,
    output logic [1:0]  wr_len,
    output logic [15:0] wr_data,
    input  logic        wr_done,
    input  logic        wr_err
);

    import pps_pkg::*;

    localparam int GAP_CYC = (CLK_HZ / 1000) * GAP_US / 1000;

    logic [IDX_W-1:0] step_idx;
    step_t            step;
    logic             tmr_start;
    logic             tmr_expired;

    pps_step_rom u_rom (
        .idx  (step_idx),
        .step (step)
    );

    pps_delay_timer #(.GAP_CYC(GAP_CYC)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (tmr_start),
        .expired (tmr_expired)
    );

    pps_seq_ctrl #(.PRE_COUNT(PRE_COUNT)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_req      (en_req),
        .dis_req     (dis_req),
        .step        (step),
        .step_idx    (step_idx),
        .tmr_start   (tmr_start),
        .tmr_expired (tmr_expired),
        .busy        (busy),
        .status      (status),
        .wr_req      (wr_req),
        .wr_addr     (wr_addr),
        .wr_len      (wr_len),
        .wr_data     (wr_data),
        .wr_done     (wr_done),
        .wr_err      (wr_err)
    );

endmodule

// File: tb/sim_panel_pwr_seq.sv
// Bench for panel_pwr_seq. A model writer answers each request two cycles
// after it rises. CLK_HZ is scaled down so each preamble gap is 1500 cycles.
module sim_panel_pwr_seq;

    localparam int GAP = 1500;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_req = 1'b0;
    logic        dis_req = 1'b0;
    logic        busy;
    logic [1:0]  status;
    logic        wr_req;
    logic [7:0]  wr_addr;
    logic [1:0]  wr_len;
    logic [15:0] wr_data;
    logic        wr_done = 1'b0;
    logic        wr_err = 1'b0;

    always #4 clk = ~clk;

    panel_pwr_seq #(.CLK_HZ(1_000_000), .GAP_US(1500), .PRE_COUNT(3)) u0 (
        .clk(clk), .rst_n(rst_n), .en_req(en_req), .dis_req(dis_req),
        .busy(busy), .status(status), .wr_req(wr_req), .wr_addr(wr_addr),
        .wr_len(wr_len), .wr_data(wr_data), .wr_done(wr_done), .wr_err(wr_err)
    );

    // Expected configuration writes, each {len, addr, data} (R6).
    localparam logic [25:0] EXP_PU [41] = '{
        {2'd1,8'hB0,16'h0017}, {2'd1,8'hBC,16'h0080}, {2'd1,8'h3B,16'h0000},
        {2'd1,8'hB0,16'h0016}, {2'd2,8'hB8,16'hFFF9}, {2'd0,8'h11,16'h0000},
        {2'd1,8'hBA,16'h0001}, {2'd1,8'hBB,16'h0000}, {2'd1,8'h3A,16'h0060},
        {2'd1,8'hBF,16'h0010}, {2'd1,8'hB1,16'h0056}, {2'd1,8'hB2,16'h0033},
        {2'd1,8'hB3,16'h0011}, {2'd1,8'hB3,16'h0011}, {2'd1,8'hB4,16'h0002},
        {2'd1,8'hB5,16'h002B}, {2'd1,8'hB6,16'h0040}, {2'd1,8'hB7,16'h0003},
        {2'd1,8'hB9,16'h0004}, {2'd1,8'hBD,16'h0004}, {2'd1,8'hBE,16'h0000},
        {2'd1,8'hC0,16'h0011}, {2'd1,8'hC1,16'h0011}, {2'd1,8'hC2,16'h0011},
        {2'd2,8'hC3,16'h2040}, {2'd2,8'hC4,16'h60C0}, {2'd2,8'hC5,16'h1020},
        {2'd2,8'hC6,16'h60C0}, {2'd2,8'hC7,16'h5533}, {2'd1,8'hC8,16'h0000},
        {2'd1,8'hC9,16'h0000}, {2'd1,8'hCA,16'h0000}, {2'd2,8'hEC,16'h01F0},
        {2'd1,8'hCF,16'h0002}, {2'd2,8'hD0,16'h0804}, {2'd1,8'hD1,16'h0001},
        {2'd2,8'hD2,16'h0000}, {2'd2,8'hD3,16'h0D0E}, {2'd2,8'hD4,16'h11A4},
        {2'd1,8'hD5,16'h000E}, {2'd0,8'h29,16'h0000}
    };

    // Expected power-down writes (R8).
    localparam logic [25:0] EXP_PD [4] = '{
        {2'd0,8'h28,16'h0000}, {2'd2,8'hB8,16'h8002},
        {2'd0,8'h10,16'h0000}, {2'd1,8'hB0,16'h0000}
    };

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int n_req = 0;
    int err_idx = -1;
    int lat = 0;
    int hold_bad = 0;
    int gap_bad = 0;
    logic prev_req = 1'b0;
    logic [25:0] log_e [64];
    int          log_t [64];

    // Model writer: logs each request, answers after two cycles.
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (wr_done && wr_req) gap_bad = gap_bad + 1;
        wr_done = 1'b0;
        wr_err  = 1'b0;
        if (wr_req) begin
            if (!prev_req) begin
                if (n_req < 64) begin
                    log_e[n_req] = {wr_len, wr_addr, wr_data};
                    log_t[n_req] = cyc;
                end
                n_req = n_req + 1;
                lat = 0;
            end else if (n_req <= 64 && {wr_len, wr_addr, wr_data} != log_e[n_req-1]) begin
                hold_bad = hold_bad + 1;
            end
            lat = lat + 1;
            if (lat == 2) begin
                wr_done = 1'b1;
                wr_err  = ((n_req - 1) == err_idx);
            end
        end
        prev_req = wr_req;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Pulses the chosen strobes for one cycle and waits for busy to fall.
    task automatic run_seq(input bit en, input bit dis, input int eidx);
        n_req = 0;
        err_idx = eidx;
        @(negedge clk);
        en_req = en;
        dis_req = dis;
        @(negedge clk);
        en_req = 1'b0;
        dis_req = 1'b0;
        while (busy) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        errors = errors + 1;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R1 busy in reset", 32'(busy), 0);
        chk(wr_req == 1'b0, "R1 wr_req in reset", 32'(wr_req), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(status == 2'b00, "R1 status after reset", 32'(status), 0);

        // Power-up; strobes mid-run must be ignored (R9) and status cleared (R11).
        n_req = 0;
        err_idx = -1;
        @(negedge clk);
        en_req = 1'b1;
        @(negedge clk);
        en_req = 1'b0;
        repeat (100) @(negedge clk);
        chk(busy == 1'b1, "R9 busy while running", 32'(busy), 1);
        chk(status == 2'b00, "R11 status cleared at start", 32'(status), 0);
        en_req = 1'b1;
        dis_req = 1'b1;
        @(negedge clk);
        en_req = 1'b0;
        dis_req = 1'b0;
        while (busy) @(negedge clk);
        chk(n_req == 44, "R9 request count with strobes while busy", 32'(n_req), 44);
        for (int i = 0; i < 3; i++)
            chk(log_e[i] == 26'd0, "R3 preamble write", 32'(log_e[i]), 0);
        for (int i = 0; i < 3; i++)
            chk(log_t[i+1] - log_t[i] == GAP + 2, "R4 preamble gap",
                32'(log_t[i+1] - log_t[i]), 32'(GAP + 2));
        // Vector table walk over the configuration writes (R6).
        for (int i = 0; i < 41; i++)
            chk(log_e[i+3] == EXP_PU[i], "R6 config step",
                32'(log_e[i+3]), 32'(EXP_PU[i]));
        chk(status == 2'b01, "R7 clean power-up status", 32'(status), 1);

        // R11: status held in idle
        repeat (20) @(negedge clk);
        chk(status == 2'b01, "R11 status held", 32'(status), 1);

        // R8: power-down order and status
        run_seq(1'b0, 1'b1, -1);
        chk(n_req == 4, "R8 power-down count", 32'(n_req), 4);
        for (int i = 0; i < 4; i++)
            chk(log_e[i] == EXP_PD[i], "R8 power-down step",
                32'(log_e[i]), 32'(EXP_PD[i]));
        chk(status == 2'b01, "R8 power-down status", 32'(status), 1);

        // R7: configuration error is accumulated and the list still completes
        run_seq(1'b1, 1'b0, 10);
        chk(n_req == 44, "R7 count with config error", 32'(n_req), 44);
        chk(log_e[43] == EXP_PU[40], "R7 last write still sent",
            32'(log_e[43]), 32'(EXP_PU[40]));
        chk(status == 2'b10, "R7 error status", 32'(status), 2);

        // R5: preamble error aborts
        run_seq(1'b1, 1'b0, 1);
        chk(status == 2'b11, "R5 abort status", 32'(status), 3);
        repeat (GAP + 100) @(negedge clk);
        chk(n_req == 2, "R5 no write after abort", 32'(n_req), 2);
        chk(wr_req == 1'b0, "R5 request low after abort", 32'(wr_req), 0);
        chk(status == 2'b11, "R11 abort status held", 32'(status), 3);

        // R10: both strobes in idle select power-down
        run_seq(1'b1, 1'b1, -1);
        chk(n_req == 4, "R10 count", 32'(n_req), 4);
        chk(log_e[0] == EXP_PD[0], "R10 first write", 32'(log_e[0]), 32'(EXP_PD[0]));
        chk(status == 2'b01, "R10 status", 32'(status), 1);

        // R8/R7: power-down error still completes all four writes
        run_seq(1'b0, 1'b1, 2);
        chk(n_req == 4, "R8 count with error", 32'(n_req), 4);
        chk(status == 2'b10, "R7 power-down error status", 32'(status), 2);

        // R2: handshake discipline over the whole run
        chk(hold_bad == 0, "R2 request held stable", 32'(hold_bad), 0);
        chk(gap_bad == 0, "R2 request low after done", 32'(gap_bad), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule